// File: doc/BRIEF.md
# Thermal Threshold Interrupt Monitor

The monitor takes a 9-bit temperature code from an on-chip sensor and checks it against eight trigger levels. Each level has its own rising threshold and its own falling threshold. When a sample crosses a rising threshold upward, the block latches a pending bit for that level. When a sample crosses a falling threshold downward, it latches a separate pending bit. A single interrupt line is the OR of every pending bit whose enable is set.

Software reaches the block over a simple 32-bit register bus. Writes are strobed by `bus_sel` and `bus_wr` and take effect at the clock edge. Read data is combinational from the address while `bus_sel` is high. The bus gives access to control, thresholds, interrupt enables, interrupt pending, the last accepted temperature and an emulation register.

Emulation lets software force the code that is compared and stored, in place of the sensor code. A power-down-detect option discards samples taken while the sensor reports that it is powered down. The current-temperature register then keeps its last value.

Top module: `thermal_trip_monitor`

## Requirements
- R1: After reset every register reads zero, except the threshold fields. Every rising threshold field reads 0x1FF and every falling threshold field reads 0. `irq` is low.
- R2: Rising thresholds are at 0x50, 0x54, 0x58 and 0x5C. Falling thresholds are at 0x60, 0x64, 0x68 and 0x6C. The register at base+4k holds level 7-2k in bits [24:16] and level 6-2k in bits [8:0]. All other bits read 0.
- R3: The control register is at 0x20. Bit 0 is the core enable and bit 23 is the power-down-detect enable. A sample (`sens_valid` high for one cycle) is accepted only while bit 0 is 1. A sample that is not accepted changes neither the current temperature nor any pending bit.
- R4: An accepted sample sets rising pending bit i (bit i of 0x118) on the same clock edge when two conditions hold. The code must be at least rising threshold i. The previous accepted sample must have been below it, and the reset state counts as below. A level that stays at or above its threshold does not fire again.
- R5: An accepted sample sets falling pending bit i (bit 16+i of 0x118) when two conditions hold. The code must be at most falling threshold i. The previous accepted sample must have been above it, and the reset state counts as at or below.
- R6: Writing the pending register at 0x118 clears each bit written as 1 and leaves each bit written as 0 unchanged. An event in the same cycle as the clear keeps the bit set.
- R7: The interrupt enable register is at 0x110. Bits [7:0] enable the rising levels and bits [23:16] enable the falling levels. Other bits read 0. `irq` is high in the same cycle as any pending bit whose enable is 1, and low otherwise.
- R8: The emulation register is at 0x160. Bit 0 enables emulation and bits [15:7] hold a code. While bit 0 is 1, accepted samples use that code instead of `sens_code`, both for comparison and for the current temperature.
- R9: While control bit 23 is 1 and `sens_pdn` is high, samples are dropped. The current temperature and pending bits keep their values.
- R10: The current temperature reads at 0x40 in bits [8:0], with upper bits 0. It updates on the edge that accepts a sample. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| sens_valid | input | 1 | One-cycle sample strobe from the sensor |
| sens_code | input | 9 | Sensor temperature code |
| sens_pdn | input | 1 | Sensor reports it is powered down |
| irq | output | 1 | Interrupt, OR of enabled pending bits |

## Verification
The hardest case is an event and a pending clear landing on the same clock edge. To set it up, the bench first moves the temperature away and back so that the levels are armed again. It then drives the sample strobe and a write of ones to the same pending bits in one bus cycle, and expects those bits to stay set. The history that gates repeat events is equally indirect. The bench reaches it by stepping the code through sequences above, between and below thresholds, so that each new event depends on which side of each level the previous accepted sample lay.

// File: rtl/thm_pkg.sv
package thm_pkg;
  localparam int CODE_W     = 9;
  localparam int LVL_COUNT  = 8;
  localparam int ADDR_W     = 12;
  localparam int FALL_SHIFT = 16;

  localparam int OFF_CTRL  = 'h020;
  localparam int OFF_TEMP  = 'h040;
  localparam int OFF_RISE  = 'h050;
  localparam int OFF_FALL  = 'h060;
  localparam int OFF_INTEN = 'h110;
  localparam int OFF_PEND  = 'h118;
  localparam int OFF_EMUL  = 'h160;

  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_PD_BIT = 23;
  localparam int EMUL_EN_BIT = 0;
  localparam int EMUL_LSB    = 7;
  localparam int THR_HI_LSB  = 16;

  typedef struct packed {
    logic              core_en;
    logic              pd_en;
    logic              emul_en;
    logic [CODE_W-1:0] emul_code;
  } thm_cfg_t;
endpackage

// File: rtl/thm_regs.sv
module thm_regs
  import thm_pkg::*;
#(
  parameter int NLVL = LVL_COUNT,
  parameter int CW   = CODE_W,
  parameter int AW   = ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [AW-1:0]            bus_addr,
  input  logic [31:0]              bus_wdata,
  input  logic [CW-1:0]            cur_temp,
  input  logic [NLVL-1:0]          pend_rise,
  input  logic [NLVL-1:0]          pend_fall,
  output logic [31:0]              bus_rdata,
  output thm_cfg_t                 cfg,
  output logic [NLVL-1:0][CW-1:0]  rise_thr,
  output logic [NLVL-1:0][CW-1:0]  fall_thr,
  output logic [NLVL-1:0]          en_rise,
  output logic [NLVL-1:0]          en_fall,
  output logic [NLVL-1:0]          clr_rise,
  output logic [NLVL-1:0]          clr_fall
);
  localparam int NREG = NLVL / 2;
  localparam int FS   = FALL_SHIFT;

  logic                    wr;
  logic                    core_q, core_d, pd_q, pd_d;
  logic                    emen_q, emen_d;
  logic [CW-1:0]           emcode_q, emcode_d;
  logic [NLVL-1:0]         enr_q, enr_d, enf_q, enf_d;
  logic [NLVL-1:0][CW-1:0] rise_q, rise_d, fall_q, fall_d;

  assign wr = bus_sel & bus_wr;

  // next-state for all writable state
  always_comb begin
    core_d   = core_q;
    pd_d     = pd_q;
    emen_d   = emen_q;
    emcode_d = emcode_q;
    enr_d    = enr_q;
    enf_d    = enf_q;
    rise_d   = rise_q;
    fall_d   = fall_q;
    if (wr && bus_addr == AW'(OFF_CTRL)) begin
      core_d = bus_wdata[CTRL_EN_BIT];
      pd_d   = bus_wdata[CTRL_PD_BIT];
    end
    if (wr && bus_addr == AW'(OFF_EMUL)) begin
      emen_d   = bus_wdata[EMUL_EN_BIT];
      emcode_d = bus_wdata[EMUL_LSB +: CW];
    end
    if (wr && bus_addr == AW'(OFF_INTEN)) begin
      enr_d = bus_wdata[NLVL-1:0];
      enf_d = bus_wdata[FS +: NLVL];
    end
    for (int k = 0; k < NREG; k++) begin
      if (wr && bus_addr == AW'(OFF_RISE + 4*k)) begin
        rise_d[NLVL-1-2*k] = bus_wdata[THR_HI_LSB +: CW];
        rise_d[NLVL-2-2*k] = bus_wdata[CW-1:0];
      end
      if (wr && bus_addr == AW'(OFF_FALL + 4*k)) begin
        fall_d[NLVL-1-2*k] = bus_wdata[THR_HI_LSB +: CW];
        fall_d[NLVL-2-2*k] = bus_wdata[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q   <= 1'b0;
      pd_q     <= 1'b0;
      emen_q   <= 1'b0;
      emcode_q <= '0;
      enr_q    <= '0;
      enf_q    <= '0;
      rise_q   <= {NLVL{{CW{1'b1}}}};
      fall_q   <= '0;
    end else begin
      core_q   <= core_d;
      pd_q     <= pd_d;
      emen_q   <= emen_d;
      emcode_q <= emcode_d;
      enr_q    <= enr_d;
      enf_q    <= enf_d;
      rise_q   <= rise_d;
      fall_q   <= fall_d;
    end
  end

  // pending clear strobes: write-one-to-clear
  always_comb begin
    clr_rise = '0;
    clr_fall = '0;
    if (wr && bus_addr == AW'(OFF_PEND)) begin
      clr_rise = bus_wdata[NLVL-1:0];
      clr_fall = bus_wdata[FS +: NLVL];
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == AW'(OFF_CTRL)) begin
        bus_rdata[CTRL_EN_BIT] = core_q;
        bus_rdata[CTRL_PD_BIT] = pd_q;
      end
      if (bus_addr == AW'(OFF_TEMP)) bus_rdata[CW-1:0] = cur_temp;
      if (bus_addr == AW'(OFF_INTEN)) begin
        bus_rdata[NLVL-1:0]  = enr_q;
        bus_rdata[FS +: NLVL] = enf_q;
      end
      if (bus_addr == AW'(OFF_PEND)) begin
        bus_rdata[NLVL-1:0]  = pend_rise;
        bus_rdata[FS +: NLVL] = pend_fall;
      end
      if (bus_addr == AW'(OFF_EMUL)) begin
        bus_rdata[EMUL_EN_BIT]    = emen_q;
        bus_rdata[EMUL_LSB +: CW] = emcode_q;
      end
      for (int k = 0; k < NREG; k++) begin
        if (bus_addr == AW'(OFF_RISE + 4*k)) begin
          bus_rdata[THR_HI_LSB +: CW] = rise_q[NLVL-1-2*k];
          bus_rdata[CW-1:0]           = rise_q[NLVL-2-2*k];
        end
        if (bus_addr == AW'(OFF_FALL + 4*k)) begin
          bus_rdata[THR_HI_LSB +: CW] = fall_q[NLVL-1-2*k];
          bus_rdata[CW-1:0]           = fall_q[NLVL-2-2*k];
        end
      end
    end
  end

  assign cfg.core_en   = core_q;
  assign cfg.pd_en     = pd_q;
  assign cfg.emul_en   = emen_q;
  assign cfg.emul_code = emcode_q;
  assign rise_thr      = rise_q;
  assign fall_thr      = fall_q;
  assign en_rise       = enr_q;
  assign en_fall       = enf_q;

  AST_RISE_TOP_PACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == AW'(OFF_RISE)) |=>
      (rise_thr[NLVL-1] == $past(bus_wdata[THR_HI_LSB +: CW]))); // R2
endmodule

// File: rtl/thm_sample.sv
module thm_sample
  import thm_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sens_valid,
  input  logic [CW-1:0] sens_code,
  input  logic          sens_pdn,
  input  thm_cfg_t      cfg,
  output logic          accept,
  output logic [CW-1:0] smp_code,
  output logic [CW-1:0] cur_temp
);
  logic          blocked;
  logic [CW-1:0] temp_q, temp_d;

  assign blocked  = cfg.pd_en & sens_pdn;
  assign accept   = sens_valid & cfg.core_en & ~blocked;
  assign smp_code = cfg.emul_en ? cfg.emul_code : sens_code;

  always_comb begin
    temp_d = temp_q;
    if (accept) temp_d = smp_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) temp_q <= '0;
    else        temp_q <= temp_d;
  end

  assign cur_temp = temp_q;

  AST_PD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pd_en && sens_pdn) |=> $stable(cur_temp)); // R9
  AST_EMUL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg.emul_en) |=> (cur_temp == $past(cfg.emul_code))); // R8
endmodule

// File: rtl/thm_cmp.sv
module thm_cmp
  import thm_pkg::*;
#(
  parameter int NLVL = LVL_COUNT,
  parameter int CW   = CODE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic [CW-1:0]           smp_code,
  input  logic [NLVL-1:0][CW-1:0] rise_thr,
  input  logic [NLVL-1:0][CW-1:0] fall_thr,
  output logic [NLVL-1:0]         evt_rise,
  output logic [NLVL-1:0]         evt_fall
);
  for (genvar i = 0; i < NLVL; i++) begin : g_lvl
    logic ge_now, le_now;
    logic ge_q, ge_d, le_q, le_d;

    assign ge_now = (smp_code >= rise_thr[i]);
    assign le_now = (smp_code <= fall_thr[i]);

    always_comb begin
      ge_d = ge_q;
      le_d = le_q;
      if (accept) begin
        ge_d = ge_now;
        le_d = le_now;
      end
    end

    // history resets to the cool side: below rising, at/below falling
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ge_q <= 1'b0;
        le_q <= 1'b1;
      end else begin
        ge_q <= ge_d;
        le_q <= le_d;
      end
    end

    assign evt_rise[i] = accept & ge_now & ~ge_q;
    assign evt_fall[i] = accept & le_now & ~le_q;

    AST_RISE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      evt_rise[i] |=> !evt_rise[i]); // R4
    AST_FALL_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      evt_fall[i] |=> !evt_fall[i]); // R5
  end
endmodule

// File: rtl/thermal_trip_monitor.sv
module thermal_trip_monitor
  import thm_pkg::*;
#(
  parameter int NLVL = LVL_COUNT,
  parameter int CW   = CODE_W,
  parameter int AW   = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          sens_valid,
  input  logic [CW-1:0] sens_code,
  input  logic          sens_pdn,
  output logic          irq
);
  thm_cfg_t                cfg;
  logic [NLVL-1:0][CW-1:0] rise_thr, fall_thr;
  logic [NLVL-1:0]         en_rise, en_fall, clr_rise, clr_fall;
  logic [NLVL-1:0]         evt_rise, evt_fall;
  logic [NLVL-1:0]         pr_q, pr_d, pf_q, pf_d;
  logic                    accept;
  logic [CW-1:0]           smp_code, cur_temp;

  thm_regs #(.NLVL(NLVL), .CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cur_temp(cur_temp),
    .pend_rise(pr_q), .pend_fall(pf_q), .bus_rdata(bus_rdata), .cfg(cfg),
    .rise_thr(rise_thr), .fall_thr(fall_thr), .en_rise(en_rise),
    .en_fall(en_fall), .clr_rise(clr_rise), .clr_fall(clr_fall)
  );

  thm_sample #(.CW(CW)) u_sample (
    .clk(clk), .rst_n(rst_n), .sens_valid(sens_valid), .sens_code(sens_code),
    .sens_pdn(sens_pdn), .cfg(cfg), .accept(accept), .smp_code(smp_code),
    .cur_temp(cur_temp)
  );

  thm_cmp #(.NLVL(NLVL), .CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .smp_code(smp_code),
    .rise_thr(rise_thr), .fall_thr(fall_thr), .evt_rise(evt_rise),
    .evt_fall(evt_fall)
  );

  // pending: a new event outranks a same-cycle clear
  always_comb begin
    pr_d = (pr_q & ~clr_rise) | evt_rise;
    pf_d = (pf_q & ~clr_fall) | evt_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_q <= '0;
      pf_q <= '0;
    end else begin
      pr_q <= pr_d;
      pf_q <= pf_d;
    end
  end

  assign irq = |{pr_q & en_rise, pf_q & en_fall};

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rise == '0 && clr_fall == '0) |=>
      (((pr_q & $past(pr_q)) == $past(pr_q)) &&
       ((pf_q & $past(pf_q)) == $past(pf_q)))); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise == '0 && en_fall == '0) |-> !irq); // R7
  AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.core_en && clr_rise == '0 && clr_fall == '0) |=>
      ($stable(pr_q) && $stable(pf_q))); // R3
endmodule

// File: tb/thermal_trip_monitor_test.sv
module thermal_trip_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sens_valid, sens_pdn;
  logic [8:0]  sens_code;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  thermal_trip_monitor uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sens_valid(sens_valid), .sens_code(sens_code), .sens_pdn(sens_pdn),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic smp(input logic [8:0] code, input logic pdn,
                     input logic do_clr, input logic [31:0] clr_val);
    @(negedge clk);
    sens_valid = 1'b1; sens_code = code; sens_pdn = pdn;
    if (do_clr) begin
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h118; bus_wdata = clr_val;
    end
    @(negedge clk);
    sens_valid = 1'b0; sens_pdn = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h020, d); chk("R1 ctrl", d, 32'h0);
    rd(12'h040, d); chk("R1 temp", d, 32'h0);
    rd(12'h05C, d); chk("R1 rise reset", d, 32'h01FF01FF);
    rd(12'h064, d); chk("R1 fall reset", d, 32'h0);
    rd(12'h118, d); chk("R1 pend", d, 32'h0);
    rd(12'h160, d); chk("R1 emul", d, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_pack();
    logic [31:0] d;
    wr(12'h06C, 32'hFFFF_FFFF);
    rd(12'h06C, d); chk("R2 field mask", d, 32'h01FF01FF);
    for (int k = 0; k < 4; k++) begin
      int hi = 7 - 2*k;
      int lo = 6 - 2*k;
      wr(12'(12'h050 + 4*k), (32'(40 + 20*hi) << 16) | 32'(40 + 20*lo));
      wr(12'(12'h060 + 4*k), (32'(35 + 20*hi) << 16) | 32'(35 + 20*lo));
    end
    rd(12'h050, d); chk("R2 rise levels 7/6", d, (32'd180 << 16) | 32'd160);
    rd(12'h06C, d); chk("R2 fall levels 1/0", d, (32'd55 << 16) | 32'd35);
    rd(12'h300, d); chk("R10 unmapped", d, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    smp(9'd300, 1'b0, 1'b0, 32'h0);
    rd(12'h040, d); chk("R3 temp held while off", d, 32'h0);
    rd(12'h118, d); chk("R3 no pend while off", d, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(12'h020, 32'h1);
    wr(12'h110, 32'h00FF_00FF);
    smp(9'd85, 1'b0, 1'b0, 32'h0);
    rd(12'h040, d); chk("R10 temp", d, 32'd85);
    rd(12'h118, d); chk("R4 first rise", d, 32'h07);
    chk("R7 irq set", {31'h0, irq}, 32'h1);
    smp(9'd90, 1'b0, 1'b0, 32'h0);
    wr(12'h118, 32'h07);
    rd(12'h118, d); chk("R6 clear", d, 32'h0);
    chk("R7 irq clear", {31'h0, irq}, 32'h0);
    smp(9'd95, 1'b0, 1'b0, 32'h0);
    rd(12'h118, d); chk("R4 no repeat", d, 32'h0);
    smp(9'd130, 1'b0, 1'b0, 32'h0);
    rd(12'h118, d); chk("R4 higher levels", d, 32'h18);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(12'h118, 32'h18);
    smp(9'd50, 1'b0, 1'b0, 32'h0);
    rd(12'h118, d); chk("R5 falling levels", d, 32'h001E_0000);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(12'h118, 32'h0002_0000);
    rd(12'h118, d); chk("R6 partial clear", d, 32'h001C_0000);
    wr(12'h118, 32'h0);
    rd(12'h118, d); chk("R6 zero write", d, 32'h001C_0000);
    smp(9'd130, 1'b0, 1'b1, 32'h0000_001E);
    rd(12'h118, d); chk("R6 event beats clear", d, 32'h001C_001E);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(12'h110, 32'h0);
    rd(12'h110, d);
    chk("R7 irq masked", {31'h0, irq}, 32'h0);
    wr(12'h110, 32'h0004_0100);
    rd(12'h110, d); chk("R7 enable mask", d, 32'h0004_0000);
    chk("R7 irq by falling enable", {31'h0, irq}, 32'h1);
    wr(12'h110, 32'h00FF_00FF);
  endtask

  task automatic t_emul();
    logic [31:0] d;
    wr(12'h160, 32'h1 | (32'd200 << 7));
    rd(12'h160, d); chk("R8 emul readback", d, 32'h1 | (32'd200 << 7));
    smp(9'd10, 1'b0, 1'b0, 32'h0);
    rd(12'h040, d); chk("R8 emulated temp", d, 32'd200);
    rd(12'h118, d); chk("R8 emulated compare", d, 32'h001C_00FE);
    wr(12'h160, 32'h0);
  endtask

  task automatic t_pd();
    logic [31:0] d;
    wr(12'h020, 32'h0080_0001);
    rd(12'h020, d); chk("R3 ctrl readback", d, 32'h0080_0001);
    smp(9'd20, 1'b1, 1'b0, 32'h0);
    rd(12'h040, d); chk("R9 temp frozen", d, 32'd200);
    rd(12'h118, d); chk("R9 no events", d, 32'h001C_00FE);
    smp(9'd20, 1'b0, 1'b0, 32'h0);
    rd(12'h040, d); chk("R9 temp after pdn low", d, 32'd20);
    rd(12'h118, d); chk("R5 all falling", d, 32'h00FF_00FE);
    wr(12'h020, 32'h1);
    smp(9'd70, 1'b1, 1'b0, 32'h0);
    rd(12'h040, d); chk("R9 detect off", d, 32'd70);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    sens_valid = 1'b0; sens_code = '0; sens_pdn = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pack();
    t_disabled();
    t_rise();
    t_fall();
    t_w1c();
    t_irq();
    t_emul();
    t_pd();
    finished = 1;
    summary();
  end
endmodule